// File: doc/BRIEF.md
# Descriptor Ring Transmit/Receive Sequencer

This block drives the transmit and receive buffer descriptor rings of a 10 Mbps Ethernet controller. Both rings live in one shared descriptor memory, which the block reaches through a simple request/acknowledge word port. When the controller is switched on, the block places the transmit ring at a fixed base offset. It places the receive ring at a base offset picked by a two-bit descriptor-size code. The transmit side polls the next descriptor and starts a frame in the MAC once that descriptor is marked ready. When the MAC reports the end of transmission, the block waits out a heartbeat window. Only after that window does it write the status word back. The next frame may go out while the previous frame's status is still waiting.

On the receive side, a frame-done pulse from the MAC makes the block read the current receive descriptor. If the descriptor is empty, the block writes the frame status into it and steps the ring. If the descriptor is full, the block raises a busy interrupt and leaves the ring where it is. A graceful-stop control lets software halt transmission cleanly. No new frame is started while it is set. Frames already committed are completed and written back, and then a one-cycle acknowledge interrupt is raised. When the stop is cleared, the ring continues from the descriptor that comes next.

Top module: `desc_ring_seq`

## Requirements
- R1: On each rising edge of `ctl_enable`, the first transmit descriptor access is a read of byte offset 0xC00.
- R2: On the same rising edge, the receive ring base is taken from `ctl_dsize`: 0 gives 0xC40, 1 gives 0xC80, 2 gives 0xD00 and 3 gives 0xE00. The first received frame's status is written at that base.
- R3: A transmit descriptor whose status word has bit 15 (ready) set produces a one-cycle `tx_go` pulse. The following descriptor is fetched 8 bytes further on.
- R4: A descriptor whose status word has bit 13 (wrap) set is the last in its ring. The next access in that ring goes back to the ring's base, on both the transmit and the receive side.
- R5: The transmit status write-back request appears no sooner than HB_CYC clock cycles after `mac_tx_done` is sampled. HB_CYC is 4 µs expressed in clock cycles (800 at 200 MHz). Without port contention the request starts at most HB_CYC+4 cycles after that pulse.
- R6: The next transmit descriptor is fetched and its frame started while the previous frame's status is still waiting for its heartbeat window.
- R7: While `ctl_gstop` is 1, no new frame is started. `irq_gra` pulses exactly once, only after every committed frame has had its status written back.
- R8: After `ctl_gstop` returns to 0, transmission resumes with the next descriptor in the ring.
- R9: A status write-back stores a word with bit 15 cleared, bit 13 equal to the descriptor's wrap bit, bits 3:0 equal to the MAC status and all other bits zero. `irq_txf` or `irq_rxf` then pulses once.
- R10: A receive descriptor read with bit 15 (empty) clear raises `irq_busy`. No write follows, and the receive pointer stays on that descriptor.
- R11: While `ctl_enable` is 0, no descriptor access begins and `mac_tx_done` and `mac_rx_done` are ignored.
- R12: Once `dp_req` is raised, `dp_we`, `dp_addr` and `dp_wdata` hold steady until the cycle in which `dp_ack` is seen.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_enable | input | 1 | Controller enable; a rising edge restarts both rings |
| ctl_gstop | input | 1 | Graceful transmit stop request |
| ctl_dsize | input | 2 | Descriptor-size code selecting the receive ring base |
| mac_tx_done | input | 1 | One-cycle pulse at the end of a transmitted frame |
| mac_tx_stat | input | 4 | Transmit status bits, valid with `mac_tx_done` |
| mac_rx_done | input | 1 | One-cycle pulse when a received frame is complete |
| mac_rx_stat | input | 4 | Receive status bits, valid with `mac_rx_done` |
| tx_go | output | 1 | One-cycle pulse telling the MAC to start the next frame |
| dp_req | output | 1 | Descriptor port request, held until acknowledged |
| dp_we | output | 1 | Descriptor port write (1) or read (0) |
| dp_addr | output | 12 | Descriptor port byte address |
| dp_wdata | output | 16 | Descriptor port write data |
| dp_ack | input | 1 | Descriptor port acknowledge, one cycle |
| dp_rdata | input | 16 | Descriptor port read data, valid with `dp_ack` |
| irq_txf | output | 1 | Transmit status written back |
| irq_rxf | output | 1 | Receive status written back |
| irq_busy | output | 1 | Received frame found no empty descriptor |
| irq_gra | output | 1 | Graceful transmit stop completed |

## Verification
The bench memory acknowledges each request on the second falling edge it sees. A descriptor fetch after an enable edge, and the `tx_go` that follows it, therefore appear within about five cycles. The bench allows ten cycles before it looks. A status write-back request starts HB_CYC+2 cycles after the cycle in which `mac_tx_done` is driven, so the bench accepts any start from HB_CYC to HB_CYC+4 cycles after that pulse. It also checks, a few cycles before the window closes, that neither the write nor `irq_gra` has appeared yet. Receive write-backs, busy interrupts and the resumed fetch after the stop clears all complete within ten to twenty-five cycles, and each is inspected only after such a settling wait. Port stability is checked on every access, at the edge where the acknowledge is given.

// File: rtl/dring_pkg.sv
// Package: shared widths, descriptor bit positions, ring bases and
// the status word builder used by both ring walkers.
package dring_pkg;

    localparam int unsigned ADDR_W  = 12;
    localparam int unsigned DATA_W  = 16;
    localparam int unsigned STAT_W  = 4;
    localparam int unsigned RDY_BIT  = 15;  // ready (tx) / empty (rx)
    localparam int unsigned WRAP_BIT = 13;  // last descriptor of ring

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [DATA_W-1:0] word_t;
    typedef logic [STAT_W-1:0] stat_t;

    localparam addr_t TX_BASE = 12'hC00;

    // Receive ring base for a descriptor-size code.
    function automatic addr_t rx_base(input logic [1:0] code);
        case (code)
            2'd0:    return 12'hC40;
            2'd1:    return 12'hC80;
            2'd2:    return 12'hD00;
            default: return 12'hE00;
        endcase
    endfunction

    // Status word written back when a descriptor is handed back.
    function automatic word_t done_word(input logic wrap, input stat_t st);
        word_t w;
        w = '0;
        w[WRAP_BIT] = wrap;
        w[STAT_W-1:0] = st;
        return w;
    endfunction

endpackage

// File: rtl/dring_ptr.sv
// Module: ring pointer. Holds the current descriptor address of one
// ring. Reloads from base_in on restart and remembers that base for
// wrapping. Steps by STEP bytes, or back to the base when the
// descriptor just consumed carried the wrap bit.
// Assumes: restart and adv are never both set in one cycle by callers
// that rely on the step; restart takes precedence.
module dring_ptr
    import dring_pkg::*;
#(
    parameter int unsigned STEP = 8
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  restart,
    input  addr_t base_in,
    input  logic  adv,
    input  logic  wrap,
    output addr_t ptr
);

    addr_t base_q;

    // Pointer and base register update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            ptr    <= '0;
        end else if (restart) begin
            base_q <= base_in;
            ptr    <= base_in;
        end else if (adv) begin
            ptr <= wrap ? base_q : ptr + addr_t'(STEP);
        end
    end

endmodule

// File: rtl/dring_mport.sv
// Module: descriptor port arbiter. Serves NCL clients over one
// request/acknowledge word port, one access at a time. The lowest
// client index wins. A client holds its request until its done bit
// pulses, and drops it in the following cycle.
// Assumes: dp_ack only arrives while dp_req is high.
module dring_mport
    import dring_pkg::*;
#(
    parameter int unsigned NCL = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCL-1:0] cl_req,
    input  logic [NCL-1:0] cl_we,
    input  addr_t          cl_addr  [NCL],
    input  word_t          cl_wdata [NCL],
    output logic [NCL-1:0] cl_done,
    output logic           dp_req,
    output logic           dp_we,
    output addr_t          dp_addr,
    output word_t          dp_wdata,
    input  logic           dp_ack
);

    localparam int unsigned IW = (NCL > 1) ? $clog2(NCL) : 1;

    logic [IW-1:0] pick;
    logic [IW-1:0] owner;
    logic          busy;

    // Fixed-priority choice among waiting clients.
    always_comb begin
        pick = '0;
        for (int i = NCL - 1; i >= 0; i--) begin
            if (cl_req[i]) pick = IW'(i);
        end
    end

    // Grant, hold and release of the shared port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            owner    <= '0;
            dp_we    <= 1'b0;
            dp_addr  <= '0;
            dp_wdata <= '0;
        end else if (busy) begin
            if (dp_ack) busy <= 1'b0;
        end else if (|cl_req) begin
            busy     <= 1'b1;
            owner    <= pick;
            dp_we    <= cl_we[pick];
            dp_addr  <= cl_addr[pick];
            dp_wdata <= cl_wdata[pick];
        end
    end

    assign dp_req = busy;

    // One done strobe per client.
    for (genvar g = 0; g < NCL; g++) begin : g_done
        assign cl_done[g] = busy && dp_ack && (owner == IW'(g));
    end

endmodule

// File: rtl/dring_tx.sv
// Module: transmit ring walker. Polls the current transmit descriptor
// and starts a frame when it is ready. Holds the sent frame through a
// heartbeat window of HB_CYC cycles, then writes its status back.
// Implements the graceful stop and its acknowledge.
// Assumes: a frame lasts longer than HB_CYC, so at most one frame waits
// in the heartbeat stage when the next mac_tx_done arrives.
module dring_tx
    import dring_pkg::*;
#(
    parameter int unsigned HB_CYC   = 800,
    parameter int unsigned POLL_CYC = 16,
    parameter int unsigned STEP     = 8
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  enable,
    input  logic  en_rise,
    input  logic  gstop,
    input  logic  tx_done,
    input  stat_t tx_stat,
    input  logic  rd_rdy,
    input  logic  rd_wrap,
    input  logic  fetch_done,
    input  logic  wb_done,
    output logic  fetch_req,
    output addr_t fetch_addr,
    output logic  wb_req,
    output addr_t wb_addr,
    output word_t wb_data,
    output logic  tx_go,
    output logic  irq_txf,
    output logic  irq_gra,
    output logic  busy
);

    localparam int unsigned HBW = $clog2(HB_CYC + 1);
    localparam int unsigned PW  = $clog2(POLL_CYC + 1);

    logic           f_pend;
    logic [PW-1:0]  poll_cnt;
    logic           x_v, x_wrap;
    addr_t          x_addr;
    logic           h_v, h_wrap;
    addr_t          h_addr;
    stat_t          h_stat;
    logic [HBW-1:0] h_cnt;
    logic           gra_sent;
    logic           launch;
    addr_t          ptr;

    assign launch = f_pend && fetch_done && rd_rdy;

    dring_ptr #(.STEP(STEP)) u_ptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (en_rise),
        .base_in (TX_BASE),
        .adv     (launch && enable),
        .wrap    (rd_wrap),
        .ptr     (ptr)
    );

    // Descriptor polling: issue, complete, back off when not ready.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            f_pend   <= 1'b0;
            poll_cnt <= '0;
        end else if (f_pend) begin
            if (fetch_done) begin
                f_pend <= 1'b0;
                if (!rd_rdy) poll_cnt <= PW'(POLL_CYC);
            end
        end else if (poll_cnt != '0) begin
            poll_cnt <= poll_cnt - 1'b1;
        end else if (!x_v && !gstop) begin
            f_pend <= 1'b1;
        end
    end

    // Frame on the wire: loaded at launch, released at end of frame.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            x_v    <= 1'b0;
            x_wrap <= 1'b0;
            x_addr <= '0;
        end else if (launch) begin
            x_v    <= 1'b1;
            x_wrap <= rd_wrap;
            x_addr <= ptr;
        end else if (tx_done && x_v) begin
            x_v <= 1'b0;
        end
    end

    // Start strobe to the MAC.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) tx_go <= 1'b0;
        else                   tx_go <= launch;
    end

    // Heartbeat stage: count the window, then hand the status back.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            h_v    <= 1'b0;
            h_wrap <= 1'b0;
            h_addr <= '0;
            h_stat <= '0;
            h_cnt  <= '0;
        end else if (tx_done && x_v) begin
            h_v    <= 1'b1;
            h_wrap <= x_wrap;
            h_addr <= x_addr;
            h_stat <= tx_stat;
            h_cnt  <= HBW'(HB_CYC);
        end else if (h_v && h_cnt != '0) begin
            h_cnt <= h_cnt - 1'b1;
        end else if (h_v && wb_done) begin
            h_v <= 1'b0;
        end
    end

    // Write-back interrupt.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) irq_txf <= 1'b0;
        else                   irq_txf <= h_v && wb_done;
    end

    // Graceful stop acknowledge: one pulse once everything drained.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable || !gstop) begin
            gra_sent <= 1'b0;
            irq_gra  <= 1'b0;
        end else if (!gra_sent && !busy) begin
            gra_sent <= 1'b1;
            irq_gra  <= 1'b1;
        end else begin
            irq_gra <= 1'b0;
        end
    end

    assign busy       = f_pend || x_v || h_v;
    assign fetch_req  = f_pend;
    assign fetch_addr = ptr;
    assign wb_req     = h_v && (h_cnt == '0);
    assign wb_addr    = h_addr;
    assign wb_data    = done_word(h_wrap, h_stat);

endmodule

// File: rtl/dring_rx.sv
// Module: receive ring walker. On a frame-done pulse it reads the
// current receive descriptor. If that descriptor is empty, it writes
// the status and steps the ring. Otherwise it raises busy and stays.
// Assumes: mac_rx_done pulses arriving while a frame is still being
// handled are dropped without notice.
module dring_rx
    import dring_pkg::*;
#(
    parameter int unsigned STEP = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enable,
    input  logic       en_rise,
    input  logic [1:0] dsize,
    input  logic       rx_done,
    input  stat_t      rx_stat,
    input  logic       rd_rdy,
    input  logic       rd_wrap,
    input  logic       acc_done,
    output logic       req,
    output logic       we,
    output addr_t      addr,
    output word_t      wdata,
    output logic       irq_rxf,
    output logic       irq_busy
);

    typedef enum logic [1:0] {RX_IDLE, RX_READ, RX_WRITE} rx_st_t;

    rx_st_t st;
    stat_t  r_stat;
    logic   r_wrap;
    addr_t  ptr;

    dring_ptr #(.STEP(STEP)) u_ptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (en_rise),
        .base_in (rx_base(dsize)),
        .adv     (st == RX_WRITE && acc_done && enable),
        .wrap    (r_wrap),
        .ptr     (ptr)
    );

    // Frame handling sequence and its interrupts.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            st       <= RX_IDLE;
            r_stat   <= '0;
            r_wrap   <= 1'b0;
            irq_rxf  <= 1'b0;
            irq_busy <= 1'b0;
        end else begin
            irq_rxf  <= 1'b0;
            irq_busy <= 1'b0;
            case (st)
                RX_IDLE: if (rx_done) begin
                    st     <= RX_READ;
                    r_stat <= rx_stat;
                end
                RX_READ: if (acc_done) begin
                    if (rd_rdy) begin
                        r_wrap <= rd_wrap;
                        st     <= RX_WRITE;
                    end else begin
                        irq_busy <= 1'b1;
                        st       <= RX_IDLE;
                    end
                end
                RX_WRITE: if (acc_done) begin
                    irq_rxf <= 1'b1;
                    st      <= RX_IDLE;
                end
                default: st <= RX_IDLE;
            endcase
        end
    end

    assign req   = (st != RX_IDLE);
    assign we    = (st == RX_WRITE);
    assign addr  = ptr;
    assign wdata = done_word(r_wrap, r_stat);

endmodule

// File: rtl/desc_ring_seq.sv
// Module: descriptor ring sequencer top. Detects the enable rising
// edge and ties the transmit and receive ring walkers to the shared
// descriptor port. Port priority: transmit status write-back first,
// then the receive side, then transmit polling.
// Assumes: descriptor memory answers each request with a one-cycle
// dp_ack, carrying read data in that same cycle.
module desc_ring_seq
    import dring_pkg::*;
#(
    parameter int unsigned CLK_MHZ  = 200,
    parameter int unsigned HB_NS    = 4000,
    parameter int unsigned POLL_CYC = 16,
    parameter int unsigned STEP     = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ctl_enable,
    input  logic        ctl_gstop,
    input  logic [1:0]  ctl_dsize,
    input  logic        mac_tx_done,
    input  logic [3:0]  mac_tx_stat,
    input  logic        mac_rx_done,
    input  logic [3:0]  mac_rx_stat,
    output logic        tx_go,
    output logic        dp_req,
    output logic        dp_we,
    output logic [11:0] dp_addr,
    output logic [15:0] dp_wdata,
    input  logic        dp_ack,
    input  logic [15:0] dp_rdata,
    output logic        irq_txf,
    output logic        irq_rxf,
    output logic        irq_busy,
    output logic        irq_gra
);

    localparam int unsigned HB_CYC = CLK_MHZ * HB_NS / 1000;
    localparam int unsigned NCL    = 3;
    localparam int unsigned C_TXWB = 0;
    localparam int unsigned C_RX   = 1;
    localparam int unsigned C_TXF  = 2;

    logic           en_q, en_rise;
    logic [NCL-1:0] cl_req, cl_we, cl_done;
    addr_t          cl_addr  [NCL];
    word_t          cl_wdata [NCL];
    logic           txf_req, tx_wb_req, rx_req, rx_we, tx_busy;
    addr_t          txf_addr, txwb_addr, rx_addr;
    word_t          txwb_data, rx_wdata;
    logic           rd_rdy, rd_wrap;
    logic           unused_rdata;

    // Enable edge detector.
    always_ff @(posedge clk) begin
        if (!rst_n) en_q <= 1'b0;
        else        en_q <= ctl_enable;
    end
    assign en_rise = ctl_enable && !en_q;

    assign rd_rdy       = dp_rdata[RDY_BIT];
    assign rd_wrap      = dp_rdata[WRAP_BIT];
    assign unused_rdata = ^dp_rdata;

    dring_tx #(
        .HB_CYC   (HB_CYC),
        .POLL_CYC (POLL_CYC),
        .STEP     (STEP)
    ) u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (ctl_enable),
        .en_rise    (en_rise),
        .gstop      (ctl_gstop),
        .tx_done    (mac_tx_done),
        .tx_stat    (mac_tx_stat),
        .rd_rdy     (rd_rdy),
        .rd_wrap    (rd_wrap),
        .fetch_done (cl_done[C_TXF]),
        .wb_done    (cl_done[C_TXWB]),
        .fetch_req  (txf_req),
        .fetch_addr (txf_addr),
        .wb_req     (tx_wb_req),
        .wb_addr    (txwb_addr),
        .wb_data    (txwb_data),
        .tx_go      (tx_go),
        .irq_txf    (irq_txf),
        .irq_gra    (irq_gra),
        .busy       (tx_busy)
    );

    dring_rx #(.STEP(STEP)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (ctl_enable),
        .en_rise  (en_rise),
        .dsize    (ctl_dsize),
        .rx_done  (mac_rx_done),
        .rx_stat  (mac_rx_stat),
        .rd_rdy   (rd_rdy),
        .rd_wrap  (rd_wrap),
        .acc_done (cl_done[C_RX]),
        .req      (rx_req),
        .we       (rx_we),
        .addr     (rx_addr),
        .wdata    (rx_wdata),
        .irq_rxf  (irq_rxf),
        .irq_busy (irq_busy)
    );

    assign cl_req[C_TXWB]   = tx_wb_req;
    assign cl_we[C_TXWB]    = 1'b1;
    assign cl_addr[C_TXWB]  = txwb_addr;
    assign cl_wdata[C_TXWB] = txwb_data;
    assign cl_req[C_RX]     = rx_req;
    assign cl_we[C_RX]      = rx_we;
    assign cl_addr[C_RX]    = rx_addr;
    assign cl_wdata[C_RX]   = rx_wdata;
    assign cl_req[C_TXF]    = txf_req;
    assign cl_we[C_TXF]     = 1'b0;
    assign cl_addr[C_TXF]   = txf_addr;
    assign cl_wdata[C_TXF]  = '0;

    dring_mport #(.NCL(NCL)) u_port (
        .clk      (clk),
        .rst_n    (rst_n),
        .cl_req   (cl_req),
        .cl_we    (cl_we),
        .cl_addr  (cl_addr),
        .cl_wdata (cl_wdata),
        .cl_done  (cl_done),
        .dp_req   (dp_req),
        .dp_we    (dp_we),
        .dp_addr  (dp_addr),
        .dp_wdata (dp_wdata),
        .dp_ack   (dp_ack)
    );

endmodule

// File: rtl/dring_chk.sv
// Module: assertion checker bound to desc_ring_seq. Counts the cycles
// since the last end of frame to bound the heartbeat window.
module dring_chk #(
    parameter int unsigned HB_CYC = 800
) (
    input logic        clk,
    input logic        rst_n,
    input logic        ctl_enable,
    input logic        ctl_gstop,
    input logic        mac_tx_done,
    input logic        tx_go,
    input logic        dp_req,
    input logic        dp_we,
    input logic [11:0] dp_addr,
    input logic [15:0] dp_wdata,
    input logic        dp_ack,
    input logic        irq_rxf,
    input logic        irq_busy,
    input logic        irq_gra,
    input logic        tx_wb_req,
    input logic        tx_busy
);

    localparam int unsigned CW = $clog2(HB_CYC + 2);
    logic [CW-1:0] since_done;

    // Cycles since the last sampled end of a transmitting frame.
    always_ff @(posedge clk) begin
        if (!rst_n) since_done <= '0;
        else if (mac_tx_done && tx_busy) since_done <= '0;
        else if (since_done <= CW'(HB_CYC)) since_done <= since_done + 1'b1;
    end

    // R5
    hb_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_wb_req |-> since_done >= CW'(HB_CYC));

    // R7
    gra_only_stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_gra |-> ctl_gstop && !tx_busy);

    // R11
    no_go_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_enable |=> !tx_go);

    // R10
    rx_irq_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({irq_rxf, irq_busy}));

    // R12
    port_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dp_req && !dp_ack |=> dp_req && $stable(dp_addr) && $stable(dp_we)
                              && $stable(dp_wdata));

endmodule

bind desc_ring_seq dring_chk #(.HB_CYC(HB_CYC)) u_dring_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctl_enable  (ctl_enable),
    .ctl_gstop   (ctl_gstop),
    .mac_tx_done (mac_tx_done),
    .tx_go       (tx_go),
    .dp_req      (dp_req),
    .dp_we       (dp_we),
    .dp_addr     (dp_addr),
    .dp_wdata    (dp_wdata),
    .dp_ack      (dp_ack),
    .irq_rxf     (irq_rxf),
    .irq_busy    (irq_busy),
    .irq_gra     (irq_gra),
    .tx_wb_req   (tx_wb_req),
    .tx_busy     (tx_busy)
);

// File: tb/desc_ring_seq_test.sv
// Bench: behavioural descriptor memory (two-edge acknowledge), MAC
// pulse tasks and event logs, checked against values worked out from
// the requirements.
module desc_ring_seq_test;

    localparam int HB = 4000 / 5;  // 4 us at a 5 ns clock

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_enable = 1'b0, ctl_gstop = 1'b0;
    logic [1:0]  ctl_dsize = 2'd0;
    logic        mac_tx_done = 1'b0, mac_rx_done = 1'b0;
    logic [3:0]  mac_tx_stat = '0, mac_rx_stat = '0;
    logic        tx_go, dp_req, dp_we, dp_ack = 1'b0;
    logic [11:0] dp_addr;
    logic [15:0] dp_wdata, dp_rdata = '0;
    logic        irq_txf, irq_rxf, irq_busy, irq_gra;

    desc_ring_seq uut (
        .clk(clk), .rst_n(rst_n), .ctl_enable(ctl_enable), .ctl_gstop(ctl_gstop),
        .ctl_dsize(ctl_dsize), .mac_tx_done(mac_tx_done), .mac_tx_stat(mac_tx_stat),
        .mac_rx_done(mac_rx_done), .mac_rx_stat(mac_rx_stat), .tx_go(tx_go),
        .dp_req(dp_req), .dp_we(dp_we), .dp_addr(dp_addr), .dp_wdata(dp_wdata),
        .dp_ack(dp_ack), .dp_rdata(dp_rdata), .irq_txf(irq_txf), .irq_rxf(irq_rxf),
        .irq_busy(irq_busy), .irq_gra(irq_gra)
    );

    always #2.5 clk = ~clk;

    typedef struct { logic [11:0] a; logic [15:0] d; int c; } acc_t;
    acc_t wq[$], rq[$];
    int   txgo_q[$], gra_q[$];
    int   cyc = 0, n_txf = 0, n_rxf = 0, n_busy = 0;
    int   checks = 0, fails = 0;
    logic [15:0] mem [0:2047];
    logic        pend = 1'b0, p_we;
    logic [11:0] p_a;
    logic [15:0] p_d;
    int          p_c;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Memory model and event logger, all on the falling edge.
    always @(negedge clk) begin
        if (dp_req && !dp_ack) begin
            if (!pend) begin
                pend = 1'b1; p_we = dp_we; p_a = dp_addr; p_d = dp_wdata; p_c = cyc;
            end else begin
                // R12: request fields unchanged while waiting
                chk(p_we == dp_we && p_a == dp_addr && (!p_we || p_d == dp_wdata),
                    "R12", "port hold", int'(dp_addr), int'(p_a));
                pend = 1'b0;
                dp_ack = 1'b1;
                if (p_we) begin
                    mem[p_a[11:1]] = p_d;
                    wq.push_back('{p_a, p_d, p_c});
                end else begin
                    dp_rdata = mem[p_a[11:1]];
                    rq.push_back('{p_a, 16'h0, p_c});
                end
            end
        end else begin
            dp_ack = 1'b0;
        end
        if (tx_go)    txgo_q.push_back(cyc);
        if (irq_gra)  gra_q.push_back(cyc);
        if (irq_txf)  n_txf++;
        if (irq_rxf)  n_rxf++;
        if (irq_busy) n_busy++;
    end

    function automatic int find_w(input logic [11:0] a);
        for (int i = 0; i < wq.size(); i++) if (wq[i].a == a) return i;
        return -1;
    endfunction

    function automatic bit read_after(input logic [11:0] a, input int c);
        for (int i = 0; i < rq.size(); i++) if (rq[i].a == a && rq[i].c >= c) return 1'b1;
        return 1'b0;
    endfunction

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic tx_end(input logic [3:0] s, output int c);
        @(negedge clk);
        mac_tx_done = 1'b1; mac_tx_stat = s; c = cyc;
        @(negedge clk);
        mac_tx_done = 1'b0;
    endtask

    task automatic rx_end(input logic [3:0] s);
        @(negedge clk);
        mac_rx_done = 1'b1; mac_rx_stat = s;
        @(negedge clk);
        mac_rx_done = 1'b0;
    endtask

    task automatic restart(input logic [1:0] ds);
        @(negedge clk);
        ctl_enable = 1'b0;
        wait_cyc(6);
        wq.delete(); rq.delete(); txgo_q.delete(); gra_q.delete();
        ctl_dsize = ds;
        ctl_enable = 1'b1;
    endtask

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual=%0d expected=0", cyc);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int d1, d2, w, nb, nr;
        for (int i = 0; i < 2048; i++) mem[i] = 16'h0000;
        wait_cyc(4);
        rst_n = 1'b1;
        wait_cyc(2);
        chk(!dp_req && !tx_go && !irq_txf && !irq_rxf && !irq_busy && !irq_gra,
            "R11", "reset outputs", int'(dp_req), 0);

        // Transmit ring: start, overlap, heartbeat, write-back, wrap.
        mem[12'hC00 >> 1] = 16'h8000;
        mem[12'hC08 >> 1] = 16'hA000;
        restart(2'd0);
        wait_cyc(10);
        chk(rq.size() > 0 && rq[0].a == 12'hC00, "R1", "first tx fetch",
            rq.size() > 0 ? int'(rq[0].a) : -1, 'hC00);
        chk(txgo_q.size() == 1, "R3", "tx_go count", txgo_q.size(), 1);
        tx_end(4'h5, d1);
        wait_cyc(20);
        chk(read_after(12'hC08, d1), "R3", "fetch +8 after frame", 0, 'hC08);
        chk(txgo_q.size() == 2 && wq.size() == 0, "R6", "second frame before status",
            txgo_q.size(), 2);
        wait_cyc(HB - 30);
        chk(find_w(12'hC00) < 0, "R5", "no write inside window", wq.size(), 0);
        wait_cyc(40);
        w = find_w(12'hC00);
        chk(w >= 0 && wq[w].c - d1 >= HB && wq[w].c - d1 <= HB + 4, "R5",
            "write-back delay", w >= 0 ? wq[w].c - d1 : -1, HB + 2);
        chk(w >= 0 && wq[w].d == 16'h0005, "R9", "tx status word",
            w >= 0 ? int'(wq[w].d) : -1, 'h0005);
        tx_end(4'hA, d2);
        wait_cyc(HB + 20);
        w = find_w(12'hC08);
        chk(w >= 0 && wq[w].d == 16'h200A, "R9", "tx status keeps wrap",
            w >= 0 ? int'(wq[w].d) : -1, 'h200A);
        chk(n_txf == 2, "R9", "irq_txf count", n_txf, 2);
        chk(read_after(12'hC00, d2) && !read_after(12'hC10, 0), "R4",
            "tx ring wraps to base", 0, 'hC00);
        chk(txgo_q.size() == 2, "R3", "no start on unready descriptor",
            txgo_q.size(), 2);

        // Graceful stop and resume.
        mem[12'hC00 >> 1] = 16'h8000;
        mem[12'hC08 >> 1] = 16'h8000;
        mem[12'hC10 >> 1] = 16'h0000;
        restart(2'd0);
        wait_cyc(10);
        chk(txgo_q.size() == 1, "R3", "frame before stop", txgo_q.size(), 1);
        ctl_gstop = 1'b1;
        wait_cyc(5);
        chk(gra_q.size() == 0, "R7", "no ack while frame in flight", gra_q.size(), 0);
        tx_end(4'h3, d1);
        wait_cyc(HB - 10);
        chk(gra_q.size() == 0, "R7", "no ack before write-back", gra_q.size(), 0);
        wait_cyc(40);
        w = find_w(12'hC00);
        chk(gra_q.size() == 1 && w >= 0 && gra_q[0] > wq[w].c, "R7",
            "single ack after write-back", gra_q.size(), 1);
        chk(txgo_q.size() == 1, "R7", "no new frame while stopped", txgo_q.size(), 1);
        @(negedge clk);
        ctl_gstop = 1'b0;
        d2 = cyc;
        wait_cyc(25);
        chk(txgo_q.size() == 2 && read_after(12'hC08, d2), "R8", "resume at next",
            txgo_q.size(), 2);
        tx_end(4'h1, d1);
        wait_cyc(HB + 20);

        // Receive ring base per size code.
        for (int ds = 0; ds < 4; ds++) begin
            logic [11:0] b;
            b = (ds == 0) ? 12'hC40 : (ds == 1) ? 12'hC80 : (ds == 2) ? 12'hD00 : 12'hE00;
            mem[12'hC00 >> 1] = 16'h0000;
            mem[b >> 1] = 16'h8000;
            restart(2'(ds));
            nr = n_rxf;
            wait_cyc(5);
            rx_end(4'h3);
            wait_cyc(12);
            w = find_w(b);
            chk(w >= 0 && wq[w].d == 16'h0003 && n_rxf == nr + 1, "R2",
                "rx base and status", w >= 0 ? int'(wq[w].a) : -1, int'(b));
        end

        // Receive wrap, busy and pointer hold (ring at 0xE00).
        mem[12'hE00 >> 1] = 16'h8000;
        mem[12'hE08 >> 1] = 16'hA000;
        restart(2'd3);
        wait_cyc(5);
        rx_end(4'h3);
        wait_cyc(12);
        rx_end(4'h7);
        wait_cyc(12);
        w = find_w(12'hE08);
        chk(w >= 0 && wq[w].d == 16'h2007, "R9", "rx status keeps wrap",
            w >= 0 ? int'(wq[w].d) : -1, 'h2007);
        nb = n_busy;
        d1 = wq.size();
        d2 = cyc;
        rx_end(4'h4);
        wait_cyc(12);
        chk(read_after(12'hE00, d2), "R4", "rx ring wraps to base", 0, 'hE00);
        chk(n_busy == nb + 1 && wq.size() == d1, "R10", "busy on full descriptor",
            n_busy - nb, 1);
        mem[12'hE00 >> 1] = 16'h8000;
        d2 = cyc;
        rx_end(4'h6);
        wait_cyc(12);
        chk(wq.size() == d1 + 1 && wq[wq.size()-1].a == 12'hE00, "R10",
            "pointer held after busy", wq.size() > 0 ? int'(wq[wq.size()-1].a) : -1, 'hE00);

        // Disabled: nothing moves.
        @(negedge clk);
        ctl_enable = 1'b0;
        mem[12'hC00 >> 1] = 16'h8000;
        wait_cyc(6);
        wq.delete(); rq.delete(); txgo_q.delete();
        nr = n_rxf;
        tx_end(4'h2, d1);
        rx_end(4'h2);
        wait_cyc(40);
        chk(wq.size() == 0 && rq.size() == 0 && txgo_q.size() == 0 && n_rxf == nr,
            "R11", "no activity while disabled", wq.size() + rq.size(), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule